// File: doc/BRIEF.md
# Serial ADC Interface Emulator

This block models the digital side of a multichannel successive-approximation converter with a serial port. Its purpose is to test the host controllers that drive such a converter. It runs on a fast system clock and oversamples the host's chip select, serial clock and data-in lines through a two-stage synchronizer.

A transaction has three parts:

- **Command.** The host lowers chip select and shifts in an 8-bit command word, most significant bit first. The first three bits name the channel.
- **Sequence.** After the eighth serial-clock rising edge and a wake-up delay, an internal oscillator starts. The oscillator is a divided copy of the system clock. It paces an acquisition window and then a conversion window. End-of-conversion is high for the whole conversion.
- **Readout.** The host reads a 16-bit result, most significant bit first, on data-out.

The result is not measured. It comes from a per-channel register that the testbench loads, and that register is sampled at the end of acquisition. If chip select rises before the conversion is complete, the sequence aborts and the block waits in a shutdown state.

States and transitions:

| State | Exits |
|-------|-------|
| IDLE | goes to CMD on a chip-select fall. |
| CMD | goes to IDLE on a chip-select rise. Goes to WAKE on the eighth serial-clock rising edge. |
| WAKE | goes to ACQ after `WAKE_CYC` system clocks. Goes to SHDN on a chip-select rise. |
| ACQ | goes to CONV on the falling edge of the sixth oscillator cycle. Goes to SHDN on a chip-select rise. |
| CONV | goes to READ on the rising edge that completes `CONV_CYC` conversion cycles. Goes to SHDN on a chip-select rise. |
| READ | goes to IDLE on a chip-select rise. |
| SHDN | goes to CMD on a chip-select fall. |

Top module: `adc_serial_emu`

## Requirements
- R1: After reset, and in IDLE while chip select is high, `dout_en`, `eoc`, `acq_win` and `dout` are low and `phase` is 0. Once a chip-select fall has passed the synchronizer, `phase` is 1, `dout_en` is 1 and `dout` is 0.
- R2: Data-in is sampled on serial-clock rising edges 1 to 8. The first three bits, MSB first, form the channel number, which selects the result register for the transaction.
- R3: The channel is fixed on the third rising edge. Command bits 4 to 8 have no effect on which channel is read.
- R4: After the eighth rising edge, the phase stays 1 for `WAKE_CYC` further system clocks before the oscillator starts and `phase` becomes 2. Counting negedge samples from the one after the eighth rise is driven, that is `WAKE_CYC`+2 samples of phase 1.
- R5: `acq_win` is high from the second oscillator rising edge to the falling edge of the sixth oscillator cycle. That is 4.5 oscillator periods, or 36 system clocks at the default `OSC_DIV`=8.
- R6: `eoc` is high, with `phase` 3, for `CONV_CYC`*`OSC_DIV`-`OSC_DIV`/2 system clocks (124 at the defaults). The channel register is sampled when acquisition ends, so a later write to it does not change this result.
- R7: When `eoc` falls at the end of a conversion, `phase` becomes 4 and `dout` shows the MSB of the sampled word. Each later serial-clock falling edge presents the next bit.
- R8: After the 16 result bits, further serial-clock falling edges before chip select rises give `dout` 0.
- R9: A chip-select rise in WAKE, ACQ or CONV gives `phase` 5 with `eoc`, `acq_win` and `dout_en` low, and the oscillator stopped. The block stays there until chip select falls, which starts a new command.
- R10: A chip-select rise during the command or the readout returns the block to `phase` 0 with `dout_en` low.
- R11: A write with `cfg_we` loads `cfg_data` into the register of channel `cfg_chan` only. Other channels keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the internal oscillator is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| din | input | 1 | Host serial data in |
| dout | output | 1 | Serial data out |
| dout_en | output | 1 | Data-out drive enable; low models high impedance |
| eoc | output | 1 | End-of-conversion, high while converting |
| acq_win | output | 1 | High during the acquisition window |
| phase | output | 3 | 0 idle, 1 command, 2 acquire, 3 convert, 4 readout, 5 shutdown |
| cfg_we | input | 1 | Result register write strobe |
| cfg_chan | input | CH_W | Channel written by `cfg_we` |
| cfg_data | input | RES_W | Value written by `cfg_we` |

## Verification
Suppose the sequencer sat in the wrong state or its oscillator edge counts were off by one. The `acq_win` and `eoc` pulses would then change length by at least half an oscillator period, which is at least four system clocks. The bench counts both pulses exactly in every transaction.

A wrong channel latch, or a wrong sampling point, would show at the first bit of the next readout. A shift mistake would show within the 16 bits, or in the zero tail after them.

An abort that left the oscillator running or the data-out enabled would show in the first few cycles after chip select rises. The shutdown phase is then held and checked for tens of cycles more.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CMD  = 3'd1,
        PH_ACQ  = 3'd2,
        PH_CONV = 3'd3,
        PH_READ = 3'd4,
        PH_SHDN = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAKE,
        ST_ACQ,
        ST_CONV,
        ST_READ,
        ST_SHDN
    } state_e;

endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            d_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/adc_int_osc.sv
module adc_int_osc #(
    parameter int OSC_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic rise,
    output logic fall
);
    localparam int OD_W = (OSC_DIV > 2) ? $clog2(OSC_DIV) : 1;
    localparam logic [OD_W-1:0] CNT_LAST = OD_W'(OSC_DIV - 1);
    localparam logic [OD_W-1:0] CNT_HALF = OD_W'(OSC_DIV / 2);

    logic [OD_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (!en)             cnt <= '0;
        else if (cnt == CNT_LAST) cnt <= '0;
        else                      cnt <= cnt + OD_W'(1);
    end

    assign rise = en && (cnt == '0);
    assign fall = en && (cnt == CNT_HALF);

    // Oscillator edges are at least two system clocks apart (R5 timing base)
    assert_osc_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    assert_osc_edge_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int CH_W  = 3,
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CH_W-1:0]  wr_sel,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_sel,
    output logic [RES_W-1:0] rd_data
);
    localparam int NCH = 1 << CH_W;

    logic [RES_W-1:0] slot [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic [RES_W-1:0] val;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              val <= '0;
            else if (we && (wr_sel == CH_W'(g)))     val <= wr_data;
        end
        assign slot[g] = val;
    end

    assign rd_data = slot[rd_sel];
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
    import adc_emu_pkg::*;
#(
    parameter int CH_W     = 3,
    parameter int RES_W    = 16,
    parameter int CMD_BITS = 8,
    parameter int WAKE_CYC = 13,
    parameter int OSC_DIV  = 8,
    parameter int CONV_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    output logic             dout,
    output logic             dout_en,
    output logic             eoc,
    output logic             acq_win,
    output logic [2:0]       phase,
    input  logic             cfg_we,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic [RES_W-1:0] cfg_data
);
    localparam int BC_W = $clog2(CMD_BITS);
    localparam int WK_W = $clog2(WAKE_CYC + 1);
    localparam int RC_W = $clog2(CONV_CYC + 8);

    localparam logic [BC_W-1:0] BC_LAST     = BC_W'(CMD_BITS - 1);
    localparam logic [BC_W-1:0] BC_CHAN     = BC_W'(CH_W - 1);
    localparam logic [WK_W-1:0] WK_LAST     = WK_W'(WAKE_CYC - 1);
    localparam logic [RC_W-1:0] RC_ACQ_ON   = RC_W'(2);
    localparam logic [RC_W-1:0] RC_ACQ_END  = RC_W'(6);
    localparam logic [RC_W-1:0] RC_BITS_END = RC_W'(6 + RES_W);
    localparam logic [RC_W-1:0] RC_CONV_END = RC_W'(5 + CONV_CYC);

    // ---------------- input conditioning ----------------
    logic [2:0] pins_s;
    logic       cs_s, sclk_s, din_s;
    logic       cs_p, sclk_p;
    logic       cs_rise, cs_fall, sclk_rise, sclk_fall;

    adc_in_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sclk, din, cs_n}),
        .d_sync  (pins_s)
    );

    assign cs_s   = pins_s[0];
    assign din_s  = pins_s[1];
    assign sclk_s = pins_s[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_p   <= 1'b1;
            sclk_p <= 1'b0;
        end else begin
            cs_p   <= cs_s;
            sclk_p <= sclk_s;
        end
    end

    assign cs_rise   =  cs_s   & ~cs_p;
    assign cs_fall   = ~cs_s   &  cs_p;
    assign sclk_rise =  sclk_s & ~sclk_p;
    assign sclk_fall = ~sclk_s &  sclk_p;

    // ---------------- state and datapath registers ----------------
    state_e           state, nxt;
    logic [BC_W-1:0]  bit_cnt;
    logic [CH_W-1:0]  ch_shift;
    logic [CH_W-1:0]  chan_q;
    logic [WK_W-1:0]  wk_cnt;
    logic [RC_W-1:0]  rise_cnt;
    logic [RES_W-1:0] samp;
    logic [RES_W-1:0] sreg;
    logic [RES_W-1:0] bank_rd;
    logic             osc_en, osc_rise, osc_fall;

    adc_int_osc #(.OSC_DIV(OSC_DIV)) u_osc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (osc_en),
        .rise  (osc_rise),
        .fall  (osc_fall)
    );

    adc_result_bank #(.CH_W(CH_W), .RES_W(RES_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wr_sel  (cfg_chan),
        .wr_data (cfg_data),
        .rd_sel  (chan_q),
        .rd_data (bank_rd)
    );

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (cs_fall) nxt = ST_CMD;
            ST_CMD: begin
                if (cs_rise)                                nxt = ST_IDLE;
                else if (sclk_rise && (bit_cnt == BC_LAST)) nxt = ST_WAKE;
            end
            ST_WAKE: begin
                if (cs_rise)                  nxt = ST_SHDN;
                else if (wk_cnt == WK_LAST)   nxt = ST_ACQ;
            end
            ST_ACQ: begin
                if (cs_rise)                                      nxt = ST_SHDN;
                else if (osc_fall && (rise_cnt == RC_ACQ_END))    nxt = ST_CONV;
            end
            ST_CONV: begin
                if (cs_rise)                                      nxt = ST_SHDN;
                else if (osc_rise && (rise_cnt == RC_CONV_END))   nxt = ST_READ;
            end
            ST_READ: if (cs_rise) nxt = ST_IDLE;
            ST_SHDN: if (cs_fall) nxt = ST_CMD;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath: command capture, counters, sample and result shift
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            ch_shift <= '0;
            chan_q   <= '0;
            wk_cnt   <= '0;
            rise_cnt <= '0;
            samp     <= '0;
            sreg     <= '0;
        end else begin
            if (state != ST_CMD)  bit_cnt <= '0;
            else if (sclk_rise)   bit_cnt <= bit_cnt + BC_W'(1);

            if ((state == ST_CMD) && sclk_rise && (bit_cnt <= BC_CHAN)) begin
                ch_shift <= {ch_shift[CH_W-2:0], din_s};
                if (bit_cnt == BC_CHAN) chan_q <= {ch_shift[CH_W-2:0], din_s};
            end

            if (state == ST_WAKE) wk_cnt <= wk_cnt + WK_W'(1);
            else                  wk_cnt <= '0;

            if (!osc_en)          rise_cnt <= '0;
            else if (osc_rise)    rise_cnt <= rise_cnt + RC_W'(1);

            if ((state == ST_ACQ) && (nxt == ST_CONV)) samp <= bank_rd;

            if ((state == ST_CONV) && osc_rise && (rise_cnt < RC_BITS_END)) begin
                sreg <= {sreg[RES_W-2:0], samp[RES_W-1]};
                samp <= {samp[RES_W-2:0], 1'b0};
            end else if ((state == ST_READ) && sclk_fall) begin
                sreg <= {sreg[RES_W-2:0], 1'b0};
            end
        end
    end

    // Outputs
    always_comb begin
        phase   = PH_IDLE;
        dout_en = 1'b0;
        eoc     = 1'b0;
        acq_win = 1'b0;
        dout    = 1'b0;
        osc_en  = 1'b0;
        unique case (state)
            ST_IDLE: phase = PH_IDLE;
            ST_CMD, ST_WAKE: begin
                phase   = PH_CMD;
                dout_en = 1'b1;
            end
            ST_ACQ: begin
                phase   = PH_ACQ;
                dout_en = 1'b1;
                osc_en  = 1'b1;
                acq_win = (rise_cnt >= RC_ACQ_ON);
            end
            ST_CONV: begin
                phase   = PH_CONV;
                dout_en = 1'b1;
                osc_en  = 1'b1;
                eoc     = 1'b1;
            end
            ST_READ: begin
                phase   = PH_READ;
                dout_en = 1'b1;
                dout    = sreg[RES_W-1];
            end
            ST_SHDN: phase = PH_SHDN;
            default: phase = PH_IDLE;
        endcase
    end

    // ---------------- assertions ----------------
    assert_chan_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE || state == ST_ACQ || state == ST_CONV) |=> $stable(chan_q));

    assert_win_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(acq_win && eoc));

    assert_eoc_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc) |-> (state == ST_READ || state == ST_SHDN));

    assert_abort_shdn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAKE || state == ST_ACQ || state == ST_CONV) && cs_rise)
            |=> (state == ST_SHDN));

    assert_osc_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_READ || state == ST_SHDN)
            |-> !(osc_rise || osc_fall));

    assert_cmd_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CMD || state == ST_READ) && cs_rise) |=> (state == ST_IDLE));
endmodule

// File: tb/adc_serial_emu_bench.sv
module adc_serial_emu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CH_W = 3, RES_W = 16, WAKE_CYC = 13, OSC_DIV = 8, CONV_CYC = 16;
    localparam int NCH = 1 << CH_W;
    localparam int EXP_WAKE = WAKE_CYC + 2;
    localparam int EXP_ACQ  = 4 * OSC_DIV + OSC_DIV / 2;
    localparam int EXP_EOC  = CONV_CYC * OSC_DIV - OSC_DIV / 2;

    // {command byte, expected channel}
    localparam int NVEC = 6;
    localparam logic [10:0] VEC [NVEC] = '{
        {8'b000_00000, 3'd0},
        {8'b111_11111, 3'd7},
        {8'b101_00000, 3'd5},
        {8'b101_11010, 3'd5},
        {8'b010_10101, 3'd2},
        {8'b011_00001, 3'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic cfg_we = 1'b0;
    logic [CH_W-1:0] cfg_chan = '0;
    logic [RES_W-1:0] cfg_data = '0;
    logic dout, dout_en, eoc, acq_win;
    logic [2:0] phase;

    int n_chk = 0, n_fail = 0;
    logic [RES_W-1:0] model [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_emu #(.CH_W(CH_W), .RES_W(RES_W), .CMD_BITS(8), .WAKE_CYC(WAKE_CYC),
                     .OSC_DIV(OSC_DIV), .CONV_CYC(CONV_CYC)) u_adc_serial_emu (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_en(dout_en), .eoc(eoc), .acq_win(acq_win), .phase(phase),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_data(cfg_data));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input int ch, input logic [RES_W-1:0] v);
        cfg_chan = CH_W'(ch); cfg_data = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        model[ch] = v;
    endtask

    task automatic send_cmd(input logic [7:0] cmd);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 7; b >= 0; b--) begin
            din = cmd[b];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            if (b > 0) begin
                repeat (4) @(negedge clk);
                sclk = 1'b0;
            end
        end
    endtask

    // Full transaction; optional write to the selected channel while converting
    task automatic run_xact(input logic [7:0] cmd, input logic [RES_W-1:0] exp,
                            input bit do_wr, input logic [RES_W-1:0] wr_val);
        int ph1, acqn, eocn, guard;
        bit wrote;
        logic [RES_W-1:0] word;
        logic tail;
        ph1 = 0; acqn = 0; eocn = 0; guard = 0; wrote = 0; tail = 1'b0;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(phase == 3'd1 && dout_en && !dout, "R1 command entry", {phase, dout_en, dout}, 5'b00110);
        send_cmd(cmd);
        do begin
            @(negedge clk);
            guard++;
            if (phase == 3'd1) ph1++;
            if (acq_win) acqn++;
            if (eoc) eocn++;
            if (guard == 4) sclk = 1'b0;
            if (do_wr && !wrote && phase == 3'd3) begin
                cfg_chan = cmd[7:5]; cfg_data = wr_val; cfg_we = 1'b1; wrote = 1;
            end else begin
                cfg_we = 1'b0;
            end
        end while (phase != 3'd4 && guard < 3000);
        cfg_we = 1'b0;
        if (wrote) model[cmd[7:5]] = wr_val;
        chk(ph1 == EXP_WAKE, "R4 wake delay", ph1, EXP_WAKE);
        chk(acqn == EXP_ACQ, "R5 acquisition window", acqn, EXP_ACQ);
        chk(eocn == EXP_EOC, "R6 eoc length", eocn, EXP_EOC);
        chk(phase == 3'd4, "R7 readout phase", phase, 4);
        word = '0;
        word[RES_W-1] = dout;
        for (int i = 1; i < RES_W + 4; i++) begin
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (6) @(negedge clk);
            if (i < RES_W) word[RES_W-1-i] = dout;
            else tail = tail | dout;
        end
        chk(word == exp, "R2/R7 result word", word, exp);
        chk(!tail, "R8 zero tail", tail, 0);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(phase == 3'd0 && !dout_en, "R10 readout exit", {phase, dout_en}, 0);
    endtask

    task automatic abort_at(input logic [2:0] target);
        int guard;
        guard = 0;
        send_cmd(8'b110_00000);
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        while (phase != target && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(phase == 3'd5, "R9 shutdown phase", phase, 5);
        chk(!eoc && !acq_win && !dout_en, "R9 outputs quiet", {eoc, acq_win, dout_en}, 0);
        repeat (60) @(negedge clk);
        chk(phase == 3'd5 && !eoc && !acq_win, "R9 shutdown held", {phase, eoc, acq_win}, 5'b10100);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(phase == 3'd0 && !dout_en && !eoc && !acq_win && !dout, "R1 reset state",
            {phase, dout_en, eoc, acq_win, dout}, 0);

        // R11 load all channels
        for (int c = 0; c < NCH; c++) load(c, RES_W'(16'hA50F ^ (c * 16'h1357)));

        // Vector table walk: R2, R3 (bits 4-8 ignored), R4-R8, R10
        for (int v = 0; v < NVEC; v++)
            run_xact(VEC[v][10:3], model[VEC[v][2:0]], 1'b0, '0);

        // R11 independence and extreme words
        load(5, 16'hFFFF);
        load(2, 16'h0000);
        run_xact(8'b101_01010, 16'hFFFF, 1'b0, '0);
        run_xact(8'b010_01010, 16'h0000, 1'b0, '0);
        load(5, 16'h8001);
        run_xact(8'b101_00000, 16'h8001, 1'b0, '0);

        // R6 sample taken at end of acquisition: write during conversion not seen
        run_xact(8'b100_00000, model[4], 1'b1, 16'h3C3C);
        run_xact(8'b100_00000, 16'h3C3C, 1'b0, '0);

        // R10 command abort
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 0; b < 3; b++) begin
            sclk = 1'b1; repeat (4) @(negedge clk);
            sclk = 1'b0; repeat (4) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(phase == 3'd0 && !dout_en, "R10 command abort", {phase, dout_en}, 0);

        // R9 aborts in acquisition and conversion, then recovery
        abort_at(3'd2);
        run_xact(8'b001_11111, model[1], 1'b0, '0);
        abort_at(3'd3);
        run_xact(8'b110_10101, model[6], 1'b0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule